// File: doc/BRIEF.md
# Host-to-Plane Address Mapper for Four-Plane Video Memory

This block sits between a host byte port and a video memory built as four byte-wide bit planes that share one address. Each host access is turned into a plane address and a 4-bit plane write enable in one step. The write or read is then carried out on the planes, which are held inside the block as four inferred RAMs. Three addressing schemes are supported. Planar mode maps the host address one-to-one onto the plane address. Odd/even mode pairs the planes by the low address bit. Chain-4 mode gives each host byte exactly one byte on exactly one plane, so one pixel spread across the planes takes four consecutive host addresses.

Two sources are ANDed to form the write enable of a plane: a plane-mask configuration input and the mask that the address translation produces. On every access all four planes are read at the translated address into a set of latches, and the latches keep the contents from before any write. A read returns one byte picked from those latches. In planar mode the plane is picked by a configuration input. In the other modes the host address picks it. The configuration inputs are sampled in the cycle the access is presented.

Top module: `hmap_top`

## Requirements
- R1: In planar mode (odd/even and chain-4 both low), the plane address equals the host address and the address-derived plane mask is 4'b1111.
- R2: In chain-4 mode, host address bits [1:0] select a single plane (address-derived mask is one-hot, bit i = plane i), and the plane address is the host address shifted right by two.
- R3: In odd/even mode, host address bit 0 = 0 gives address mask 4'b0101 (planes 0 and 2), bit 0 = 1 gives 4'b1010 (planes 1 and 3), and the plane address is the host address with bit 0 cleared.
- R4: When chain-4 and odd/even are both high, the chain-4 mapping applies.
- R5: The plane write enable (bit i = plane i) is the AND of the address mask and `cfg_plane_mask` for a write and zero for a read or an idle cycle. It appears on `plane_we`, with the plane address on `plane_addr`, in the cycle after the access. Masked-off planes keep their contents.
- R6: For a write, `plane_wdata` carries the host byte copied onto all four byte lanes (lane i = bits [8i+7:8i]) in the cycle after the access.
- R7: The plane a read returns is `cfg_read_sel` in planar mode, host address bits [1:0] in chain-4 mode, and {`cfg_read_sel`[1], host address bit 0} in odd/even mode.
- R8: `rd_valid` is high in exactly the cycle after a read access, with `rd_data` holding the selected plane byte.
- R9: Every access loads `latch_data` (lane i = plane i) with the contents of all four planes at the plane address as they were before any write in that access.
- R10: The mode, mask and read-select inputs are sampled in the access cycle, so changing them in the following cycle does not change that access's result.
- R11: While `rst` is high, `plane_we`, `plane_addr`, `plane_wdata` and `rd_valid` are driven to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | DW | Host write byte |
| cfg_plane_mask | input | 4 | Plane write mask register |
| cfg_read_sel | input | 2 | Read plane select register |
| cfg_oddeven | input | 1 | Odd/even addressing enable |
| cfg_chain4 | input | 1 | Chain-4 addressing enable |
| plane_addr | output | HOST_AW | Translated plane address of the last access |
| plane_we | output | 4 | Final per-plane write enable of the last access |
| plane_wdata | output | 4*DW | Replicated write byte of the last access |
| latch_data | output | 4*DW | Four-plane latches, loaded on every access |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW | Byte returned by the last read |

## Verification
The hardest case to reach from the ports is a configuration change that lands just after an access has been sampled. To catch a design that routes the read select or the mode combinationally into the result, the bench changes `cfg_read_sel` in the same half-cycle in which it samples the read result. A second hard case is the read-before-write content of the latches. Seeing it needs a known prior plane state, so the bench first clears every address in planar mode. It then overwrites locations in chain-4 and odd/even mode and checks the old bytes in `latch_data` against a shadow model of the planes.

// File: rtl/hmap_pkg.sv
package hmap_pkg;
  localparam int NPL = 4;

  typedef enum logic [1:0] {
    MODE_PLANAR  = 2'd0,
    MODE_ODDEVEN = 2'd1,
    MODE_CHAIN4  = 2'd2
  } hmap_mode_e;

  // chain-4 wins over odd/even when both are set
  function automatic hmap_mode_e pick_mode(input logic oddeven, input logic chain4);
    if (chain4)       return MODE_CHAIN4;
    else if (oddeven) return MODE_ODDEVEN;
    else              return MODE_PLANAR;
  endfunction
endpackage

// File: rtl/hmap_xlate.sv
module hmap_xlate
  import hmap_pkg::*;
#(
  parameter int HOST_AW = 8
) (
  input  hmap_mode_e         mode,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [1:0]         read_sel,
  output logic [HOST_AW-1:0] paddr,
  output logic [NPL-1:0]     amask,
  output logic [1:0]         rsel
);
  always_comb begin
    paddr = host_addr;
    amask = '1;
    rsel  = read_sel;
    unique case (mode)
      MODE_CHAIN4: begin
        paddr = host_addr >> 2;
        amask = NPL'(1) << host_addr[1:0];
        rsel  = host_addr[1:0];
      end
      MODE_ODDEVEN: begin
        paddr = {host_addr[HOST_AW-1:1], 1'b0};
        amask = host_addr[0] ? 4'b1010 : 4'b0101;
        rsel  = {read_sel[1], host_addr[0]};
      end
      default: begin
        paddr = host_addr;
        amask = '1;
        rsel  = read_sel;
      end
    endcase
  end
endmodule

// File: rtl/hmap_plane_ram.sv
module hmap_plane_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first: the output register takes the old word on a write
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/hmap_top.sv
module hmap_top
  import hmap_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic [3:0]         cfg_plane_mask,
  input  logic [1:0]         cfg_read_sel,
  input  logic               cfg_oddeven,
  input  logic               cfg_chain4,
  output logic [HOST_AW-1:0] plane_addr,
  output logic [3:0]         plane_we,
  output logic [4*DW-1:0]    plane_wdata,
  output logic [4*DW-1:0]    latch_data,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data
);
  localparam int BUSW = NPL * DW;

  hmap_mode_e         mode;
  logic [HOST_AW-1:0] x_paddr;
  logic [NPL-1:0]     x_amask;
  logic [1:0]         x_rsel;
  logic [NPL-1:0]     wr_en;
  logic [BUSW-1:0]    wbus;
  logic [1:0]         rsel_q;

  assign mode = pick_mode(cfg_oddeven, cfg_chain4);

  hmap_xlate #(.HOST_AW(HOST_AW)) u_xlate (
    .mode     (mode),
    .host_addr(host_addr),
    .read_sel (cfg_read_sel),
    .paddr    (x_paddr),
    .amask    (x_amask),
    .rsel     (x_rsel)
  );

  assign wr_en = (req_valid && req_write) ? (x_amask & cfg_plane_mask) : '0;
  assign wbus  = {NPL{host_wdata}};

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    hmap_plane_ram #(.AW(HOST_AW), .DW(DW)) u_ram (
      .clk  (clk),
      .en   (req_valid),
      .we   (wr_en[p]),
      .addr (x_paddr),
      .wdata(wbus[p*DW +: DW]),
      .rdata(latch_data[p*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plane_addr  <= '0;
      plane_we    <= '0;
      plane_wdata <= '0;
      rd_valid    <= 1'b0;
      rsel_q      <= '0;
    end else begin
      plane_we <= wr_en;
      rd_valid <= req_valid && !req_write;
      if (req_valid) begin
        plane_addr <= x_paddr;
        if (req_write) plane_wdata <= wbus;
        else           rsel_q      <= x_rsel;
      end
    end
  end

  assign rd_data = latch_data[rsel_q*DW +: DW];
endmodule

// File: rtl/hmap_checker.sv
module hmap_checker #(
  parameter int HOST_AW = 8,
  parameter int DW      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DW-1:0]      host_wdata,
  input logic [3:0]         cfg_plane_mask,
  input logic               cfg_oddeven,
  input logic               cfg_chain4,
  input logic [HOST_AW-1:0] plane_addr,
  input logic [3:0]         plane_we,
  input logic [4*DW-1:0]    plane_wdata,
  input logic               rd_valid
);
  assert_we_within_mask_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_write) |-> ((plane_we & ~$past(cfg_plane_mask)) == 4'b0));

  assert_no_we_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !(req_valid && req_write)) |-> (plane_we == 4'b0));

  assert_chain4_single_plane_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_write && cfg_chain4) |-> $onehot0(plane_we));

  assert_oddeven_pair_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_write && cfg_oddeven && !cfg_chain4)
      |-> (((plane_we & 4'b1010) == 4'b0) || ((plane_we & 4'b0101) == 4'b0)));

  assert_planar_addr_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && !cfg_oddeven && !cfg_chain4) |-> (plane_addr == $past(host_addr)));

  assert_wdata_copied_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_write) |-> (plane_wdata == {4{$past(host_wdata)}}));

  assert_rd_valid_timing_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rd_valid == $past(req_valid && !req_write)));
endmodule

bind hmap_top hmap_checker #(.HOST_AW(HOST_AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .host_addr(host_addr), .host_wdata(host_wdata), .cfg_plane_mask(cfg_plane_mask),
  .cfg_oddeven(cfg_oddeven), .cfg_chain4(cfg_chain4), .plane_addr(plane_addr),
  .plane_we(plane_we), .plane_wdata(plane_wdata), .rd_valid(rd_valid)
);

// File: tb/hmap_top_bench.sv
`timescale 1ns/1ps
module hmap_top_bench;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [3:0]    cfg_plane_mask = 4'hF;
  logic [1:0]    cfg_read_sel = 2'd0;
  logic          cfg_oddeven = 1'b0, cfg_chain4 = 1'b0;
  logic [AW-1:0] plane_addr;
  logic [3:0]    plane_we;
  logic [4*DW-1:0] plane_wdata, latch_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  hmap_top #(.HOST_AW(AW), .DW(DW)) u_hmap_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .cfg_plane_mask(cfg_plane_mask),
    .cfg_read_sel(cfg_read_sel), .cfg_oddeven(cfg_oddeven), .cfg_chain4(cfg_chain4),
    .plane_addr(plane_addr), .plane_we(plane_we), .plane_wdata(plane_wdata),
    .latch_data(latch_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct {
    int              due;
    int              mtag;
    logic            is_rd;
    logic            chk_latch;
    logic [AW-1:0]   paddr;
    logic [3:0]      we;
    logic [4*DW-1:0] wdata;
    logic [4*DW-1:0] latch;
    logic [DW-1:0]   rd;
    int              rtag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  logic mon_on = 1'b0, chk_latch = 1'b1;
  int   rd_tag = 7;
  logic [DW-1:0] model [4][256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Driver: translation model written from R1-style mode rules, plus shadow planes
  task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    logic [AW-1:0] pa;
    logic [3:0] am;
    logic [1:0] rs;
    int tag;
    if (cfg_chain4) begin            // R2, R4
      pa = a >> 2; am = 4'b0001 << a[1:0]; rs = a[1:0];
      tag = cfg_oddeven ? 4 : 2;
    end else if (cfg_oddeven) begin  // R3
      pa = {a[AW-1:1], 1'b0}; am = a[0] ? 4'b1010 : 4'b0101; rs = {cfg_read_sel[1], a[0]};
      tag = 3;
    end else begin                   // R1
      pa = a; am = 4'b1111; rs = cfg_read_sel;
      tag = 1;
    end
    e.due = cyc + 1; e.mtag = tag; e.is_rd = !wr; e.chk_latch = chk_latch;
    e.paddr = pa; e.rtag = rd_tag;
    e.we = wr ? (am & cfg_plane_mask) : 4'b0;
    e.wdata = {4{d}};
    for (int p = 0; p < 4; p++) e.latch[p*DW +: DW] = model[p][pa];
    e.rd = model[rs][pa];
    if (wr) for (int p = 0; p < 4; p++) if (e.we[p]) model[p][pa] = d;
    req_valid = 1'b1; req_write = wr; host_addr = a; host_wdata = d;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops expected items as their result cycle arrives
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.mtag, 32'(plane_addr), 32'(e.paddr));
        cmp(5, 32'(plane_we), 32'(e.we));                  // R5
        if (!e.is_rd) cmp(6, plane_wdata, e.wdata);        // R6
        cmp(8, 32'(rd_valid), 32'(e.is_rd));               // R8
        if (e.is_rd) cmp(e.rtag, 32'(rd_data), 32'(e.rd)); // R7 / R8 / R10
        if (e.chk_latch) cmp(9, latch_data, e.latch);      // R9
      end else begin
        cmp(8, {28'b0, plane_we, rd_valid} , 32'b0);       // R8 idle: nothing issued
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) for (int i = 0; i < 256; i++) model[p][i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    cmp(11, {19'b0, plane_we, rd_valid, plane_addr}, 32'b0);
    cmp(11, plane_wdata, 32'b0);
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;

    // R1: planar clear of every address (latches hold unknown old data here)
    chk_latch = 1'b0;
    for (int i = 0; i < 256; i++) acc(1'b1, AW'(i), 8'h00);
    chk_latch = 1'b1;

    // R5: planar write with mask 0101, then read each plane (R7 planar select)
    cfg_plane_mask = 4'b0101;
    acc(1'b1, 8'h05, 8'hA5);
    cfg_plane_mask = 4'hF;
    for (int s = 0; s < 4; s++) begin cfg_read_sel = 2'(s); acc(1'b0, 8'h05, 8'h00); end

    // R2: chain-4 pixel over four consecutive host addresses
    cfg_chain4 = 1'b1;
    acc(1'b1, 8'h40, 8'h11); acc(1'b1, 8'h41, 8'h22);
    acc(1'b1, 8'h42, 8'h33); acc(1'b1, 8'h43, 8'h44);
    for (int i = 0; i < 4; i++) acc(1'b0, AW'(8'h40 + i), 8'h00);
    // R5: plane 2 masked off in chain-4, contents must survive
    cfg_plane_mask = 4'b1011;
    acc(1'b1, 8'h42, 8'hEE);
    cfg_plane_mask = 4'hF;
    acc(1'b0, 8'h42, 8'h00);
    // R9: overwrite shows old byte in latches
    acc(1'b1, 8'h41, 8'h99);
    cfg_chain4 = 1'b0;
    cfg_read_sel = 2'd2;
    acc(1'b0, 8'h10, 8'h00);          // planar view of chain-4 data

    // R3: odd/even writes and reads
    cfg_oddeven = 1'b1;
    acc(1'b1, 8'h21, 8'h5A);
    acc(1'b1, 8'h20, 8'hC3);
    cfg_read_sel = 2'd2; acc(1'b0, 8'h21, 8'h00);
    cfg_read_sel = 2'd0; acc(1'b0, 8'h21, 8'h00);
    cfg_read_sel = 2'd2; acc(1'b0, 8'h20, 8'h00);
    cfg_plane_mask = 4'b0011;
    acc(1'b1, 8'h31, 8'h77);
    cfg_plane_mask = 4'hF;

    // R4: both modes set, chain-4 mapping wins
    cfg_chain4 = 1'b1;
    acc(1'b1, 8'h83, 8'hB6);
    acc(1'b0, 8'h83, 8'h00);
    acc(1'b0, 8'h82, 8'h00);

    // R10: change config in the cycle after a read is sampled
    cfg_chain4 = 1'b0; cfg_oddeven = 1'b0;
    cfg_read_sel = 2'd0;
    rd_tag = 10;
    acc(1'b0, 8'h05, 8'h00);
    cfg_read_sel = 2'd1; cfg_chain4 = 1'b1;
    @(negedge clk);
    cfg_chain4 = 1'b0;
    acc(1'b0, 8'h05, 8'h00);
    cfg_read_sel = 2'd0;
    rd_tag = 7;

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R8 actual=%0d pending expected=0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule